// File: doc/BRIEF.md
# Clock Control and Status Register

This block is a single 32-bit control and status word for a small clock tree. The tree has an internal RC oscillator, an external crystal oscillator and a PLL. Software uses the word to switch each source on and off. It also uses it to select crystal bypass, arm the clock-failure detector and trim the RC oscillator. Through the same word, software reads a ready flag for each source and the factory calibration byte of the RC oscillator. The register sits at offset 0 of a small, zero-wait-state bus that accepts byte, half-word and word accesses through per-lane byte enables.

Hardware also updates the word. Each oscillator's raw stable or lock signal passes through a two-flop synchronizer and becomes the matching ready flag. A low-power entry pulse clears the external oscillator and PLL enables. An interlock protects the clock that currently drives the system: software cannot switch that source off. For the PLL, the protection also covers the case where it is only selected and about to take over.

Top module: `clk_ctrl_reg`

## Requirements
- R1: After reset, offset 0 reads 0x0000_CC83, where CC is the value on `cal_i`. That means the RC enable and RC ready bits are 1, the trim field is 16, and every other writable bit is 0.
- R2: The read word is laid out as follows: bit 0 RC enable, bit 1 RC ready, bits 7:3 trim, bits 15:8 calibration, bit 16 crystal enable, bit 17 crystal ready, bit 18 bypass, bit 19 clock-detector enable, bit 24 PLL enable, bit 25 PLL ready. Bits 2, 23:20 and 31:26 always read 0.
- R3: A write changes only the bytes whose enable in `be_i` is 1, in the cycle the request is taken.
- R4: Each ready flag reads 1 exactly when its enable bit is 1 and its raw stable/lock input was high two rising clock edges earlier. A ready flag drops at once when its enable bit is cleared.
- R5: Software writes leave the three ready bits, the calibration byte and all reserved bits unchanged.
- R6: A one-cycle `lp_entry_i` pulse clears the crystal and PLL enables. It wins over a software write to those bits in the same cycle, and it leaves the RC enable unchanged.
- R7: A write of 0 to the PLL enable is ignored while `sysclk_src_i` or `sysclk_sel_i` equals 2 (PLL).
- R8: A write of 0 to the RC enable is ignored while `sysclk_src_i` is 0 (RC). A write of 0 to the crystal enable is ignored while `sysclk_src_i` is 1 (crystal).
- R9: `css_active_o` is 1 exactly when the clock-detector enable is 1 and the crystal ready flag is 1.
- R10: An access to any offset other than 0 reads 0 and changes no state. A read with no request returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | ADDR_W | Byte offset |
| be_i | input | 4 | Byte-lane enables |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle |
| irc_stable_i | input | 1 | RC oscillator stable, asynchronous |
| xosc_stable_i | input | 1 | Crystal oscillator stable, asynchronous |
| pll_lock_i | input | 1 | PLL lock, asynchronous |
| cal_i | input | CAL_W | Factory calibration value |
| lp_entry_i | input | 1 | Low-power entry pulse |
| sysclk_src_i | input | 2 | Current system clock source: 0 RC, 1 crystal, 2 PLL |
| sysclk_sel_i | input | 2 | Pending system clock selection, same coding |
| irc_en_o | output | 1 | RC oscillator enable |
| xosc_en_o | output | 1 | Crystal oscillator enable |
| xosc_byp_o | output | 1 | Crystal bypass |
| pll_en_o | output | 1 | PLL enable |
| trim_o | output | TRIM_W | RC trim |
| css_active_o | output | 1 | Clock-failure detector running |

## Verification
The checker watches four things on every cycle:
- Low-power entry always leaves the PLL and crystal enables at 0.
- A protected enable never falls without low-power entry.
- A ready flag never reads 1 while its enable is 0, and the detector never runs without the crystal enable.
- Reserved bits never read as 1.

Other behaviours need the bench's scenarios to show them. These are the exact reset word, byte-lane selection, the two-edge synchronizer delay, the writes to read-only fields that have no effect, and the isolation of other offsets.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned TRIM_W   = 5;
  localparam int unsigned CAL_W    = 8;
  localparam int unsigned TRIM_RST = 16;

  // bit positions the clock tree decodes
  localparam int unsigned B_IRC_EN  = 0;
  localparam int unsigned B_IRC_RDY = 1;
  localparam int unsigned B_TRIM    = 3;
  localparam int unsigned B_CAL     = 8;
  localparam int unsigned B_XO_EN   = 16;
  localparam int unsigned B_XO_RDY  = 17;
  localparam int unsigned B_XO_BYP  = 18;
  localparam int unsigned B_CSS     = 19;
  localparam int unsigned B_PLL_EN  = 24;
  localparam int unsigned B_PLL_RDY = 25;

  typedef enum logic [1:0] {
    SRC_IRC  = 2'd0,
    SRC_XOSC = 2'd1,
    SRC_PLL  = 2'd2
  } clk_src_e;

  typedef struct packed {
    logic              pll_en;
    logic              css_en;
    logic              xo_byp;
    logic              xo_en;
    logic [TRIM_W-1:0] trim;
    logic              irc_en;
  } ccr_ctl_t;
endpackage

// File: rtl/ccr_sync.sv
module ccr_sync #(
  parameter int unsigned        WIDTH   = 3,
  parameter int unsigned        STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ccr_fields.sv
module ccr_fields
  import ccr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [3:0]        be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              lp_entry_i,
  input  logic [1:0]        src_i,
  input  logic [1:0]        sel_i,
  output ccr_ctl_t          ctl_o
);
  ccr_ctl_t ctl_q, ctl_d;
  logic irc_lock, xo_lock, pll_lock;

  // enables that may not be cleared by software
  assign irc_lock = (src_i == SRC_IRC);
  assign xo_lock  = (src_i == SRC_XOSC);
  assign pll_lock = (src_i == SRC_PLL) || (sel_i == SRC_PLL);

  always_comb begin
    ctl_d = ctl_q;
    if (wr_i && be_i[0]) begin
      ctl_d.irc_en = wdata_i[B_IRC_EN] | (ctl_q.irc_en & irc_lock);
      ctl_d.trim   = wdata_i[B_TRIM +: TRIM_W];
    end
    if (wr_i && be_i[2]) begin
      ctl_d.xo_en  = wdata_i[B_XO_EN] | (ctl_q.xo_en & xo_lock);
      ctl_d.xo_byp = wdata_i[B_XO_BYP];
      ctl_d.css_en = wdata_i[B_CSS];
    end
    if (wr_i && be_i[3]) begin
      ctl_d.pll_en = wdata_i[B_PLL_EN] | (ctl_q.pll_en & pll_lock);
    end
    if (lp_entry_i) begin
      ctl_d.pll_en = 1'b0;
      ctl_d.xo_en  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q        <= '0;
      ctl_q.irc_en <= 1'b1;
      ctl_q.trim   <= TRIM_W'(TRIM_RST);
    end else begin
      ctl_q <= ctl_d;
    end
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/ccr_rmux.sv
module ccr_rmux
  import ccr_pkg::*;
(
  input  logic              rd_i,
  input  ccr_ctl_t          ctl_i,
  input  logic [2:0]        rdy_i,
  input  logic [CAL_W-1:0]  cal_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] word;

  always_comb begin
    word = '0;
    word[B_IRC_EN]             = ctl_i.irc_en;
    word[B_IRC_RDY]            = rdy_i[0];
    word[B_TRIM +: TRIM_W]     = ctl_i.trim;
    word[B_CAL +: CAL_W]       = cal_i;
    word[B_XO_EN]              = ctl_i.xo_en;
    word[B_XO_RDY]             = rdy_i[1];
    word[B_XO_BYP]             = ctl_i.xo_byp;
    word[B_CSS]                = ctl_i.css_en;
    word[B_PLL_EN]             = ctl_i.pll_en;
    word[B_PLL_RDY]            = rdy_i[2];
  end

  assign rdata_o = rd_i ? word : '0;
endmodule

// File: rtl/clk_ctrl_reg.sv
module clk_ctrl_reg
  import ccr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              irc_stable_i,
  input  logic              xosc_stable_i,
  input  logic              pll_lock_i,
  input  logic [7:0]        cal_i,
  input  logic              lp_entry_i,
  input  logic [1:0]        sysclk_src_i,
  input  logic [1:0]        sysclk_sel_i,
  output logic              irc_en_o,
  output logic              xosc_en_o,
  output logic              xosc_byp_o,
  output logic              pll_en_o,
  output logic [4:0]        trim_o,
  output logic              css_active_o
);
  localparam int unsigned NSRC = 3;

  logic           hit, wr, rd;
  ccr_ctl_t       ctl;
  logic [NSRC-1:0] raw, sync_q, en_vec, rdy;

  assign hit = req_i && (addr_i == '0);
  assign wr  = hit && we_i;
  assign rd  = hit && !we_i;

  assign raw = {pll_lock_i, xosc_stable_i, irc_stable_i};

  ccr_sync #(.WIDTH(NSRC), .STAGES(2), .RST_VAL(3'b001)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw),
    .q_o    (sync_q)
  );

  ccr_fields u_fields (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr),
    .be_i       (be_i),
    .wdata_i    (wdata_i),
    .lp_entry_i (lp_entry_i),
    .src_i      (sysclk_src_i),
    .sel_i      (sysclk_sel_i),
    .ctl_o      (ctl)
  );

  assign en_vec = {ctl.pll_en, ctl.xo_en, ctl.irc_en};
  assign rdy    = sync_q & en_vec;

  ccr_rmux u_rmux (
    .rd_i    (rd),
    .ctl_i   (ctl),
    .rdy_i   (rdy),
    .cal_i   (cal_i),
    .rdata_o (rdata_o)
  );

  assign irc_en_o     = ctl.irc_en;
  assign xosc_en_o    = ctl.xo_en;
  assign xosc_byp_o   = ctl.xo_byp;
  assign pll_en_o     = ctl.pll_en;
  assign trim_o       = ctl.trim;
  assign css_active_o = ctl.css_en & rdy[1];
endmodule

// File: rtl/clk_ctrl_reg_chk.sv
module clk_ctrl_reg_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] rdata_o,
  input logic        lp_entry_i,
  input logic [1:0]  sysclk_src_i,
  input logic [1:0]  sysclk_sel_i,
  input logic        irc_en_o,
  input logic        xosc_en_o,
  input logic        pll_en_o,
  input logic        css_active_o
);
  // R6
  lp_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_entry_i |=> (!pll_en_o && !xosc_en_o));

  // R7
  pll_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pll_en_o && !lp_entry_i && (sysclk_src_i == 2'd2 || sysclk_sel_i == 2'd2)) |=> pll_en_o);

  // R8
  irc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irc_en_o && sysclk_src_i == 2'd0) |=> irc_en_o);

  // R8
  xosc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xosc_en_o && !lp_entry_i && sysclk_src_i == 2'd1) |=> xosc_en_o);

  // R4
  pll_rdy_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[25] |-> pll_en_o);

  // R9
  css_needs_xosc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    css_active_o |-> xosc_en_o);

  // R2
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[31:26] == '0) && (rdata_o[23:20] == '0) && !rdata_o[2]);
endmodule

bind clk_ctrl_reg clk_ctrl_reg_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rdata_o      (rdata_o),
  .lp_entry_i   (lp_entry_i),
  .sysclk_src_i (sysclk_src_i),
  .sysclk_sel_i (sysclk_sel_i),
  .irc_en_o     (irc_en_o),
  .xosc_en_o    (xosc_en_o),
  .pll_en_o     (pll_en_o),
  .css_active_o (css_active_o)
);

// File: tb/clk_ctrl_reg_tb.sv
module clk_ctrl_reg_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [3:0]  be_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irc_stable_i = 1'b1, xosc_stable_i = 1'b0, pll_lock_i = 1'b0;
  logic [7:0]  cal_i = 8'h5A;
  logic        lp_entry_i = 1'b0;
  logic [1:0]  sysclk_src_i = 2'd0, sysclk_sel_i = 2'd0;
  logic        irc_en_o, xosc_en_o, xosc_byp_o, pll_en_o, css_active_o;
  logic [4:0]  trim_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clk_ctrl_reg u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .be_i(be_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irc_stable_i(irc_stable_i), .xosc_stable_i(xosc_stable_i), .pll_lock_i(pll_lock_i),
    .cal_i(cal_i), .lp_entry_i(lp_entry_i), .sysclk_src_i(sysclk_src_i),
    .sysclk_sel_i(sysclk_sel_i), .irc_en_o(irc_en_o), .xosc_en_o(xosc_en_o),
    .xosc_byp_o(xosc_byp_o), .pll_en_o(pll_en_o), .trim_o(trim_o),
    .css_active_o(css_active_o)
  );

  // {be, wdata, expected read-back}; starts from reset, RC is system clock
  localparam logic [67:0] VEC [6] = '{
    {4'hF, 32'hFFFF_FFFF, 32'h010D_5AFB},  // R2 R5 R8: reserved/RO ignored, RC enable kept
    {4'h1, 32'h0000_0000, 32'h010D_5A03},  // R3 R8: byte 0 only
    {4'h4, 32'h0000_0000, 32'h0100_5A03},  // R3: byte 2 only
    {4'h8, 32'h0000_0000, 32'h0000_5A03},  // R3 R7: PLL free to clear
    {4'h2, 32'hFFFF_FFFF, 32'h0000_5A03},  // R5: calibration read-only
    {4'h3, 32'h0000_0080, 32'h0000_5A83}   // R3: half-word, trim back to 16
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; be_i = be; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0; be_i = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    req_i = 1'b0; addr_i = '0;
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    rd(4'h0, r); check("R1 reset word", r, 32'h0000_5A83);
    rd(4'h4, r); check("R10 other offset read", r, 32'h0);
    #1 check("R10 idle read", rdata_o, 32'h0);

    for (int i = 0; i < 6; i++) begin
      wr(4'h0, VEC[i][67:64], VEC[i][63:32]);
      rd(4'h0, r); check($sformatf("R3 vector %0d", i), r, VEC[i][31:0]);
    end

    wr(4'h4, 4'hF, 32'hFFFF_FFFF);
    rd(4'h0, r); check("R10 write to other offset", r, 32'h0000_5A83);

    // R4 synchronizer delay and masking
    wr(4'h0, 4'h4, 32'h0001_0000);
    xosc_stable_i = 1'b1;
    @(negedge clk); rd(4'h0, r); check("R4 crystal ready after 1 edge", {31'b0, r[17]}, 32'h0);
    @(negedge clk); rd(4'h0, r); check("R4 crystal ready after 2 edges", {31'b0, r[17]}, 32'h1);
    wr(4'h0, 4'h4, 32'h0008_0000);
    rd(4'h0, r); check("R4 ready masked by enable", {31'b0, r[17]}, 32'h0);
    check("R9 detector off without crystal", {31'b0, css_active_o}, 32'h0);
    wr(4'h0, 4'h4, 32'h0009_0000);
    check("R9 detector on", {31'b0, css_active_o}, 32'h1);
    xosc_stable_i = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R9 detector off after crystal loss", {31'b0, css_active_o}, 32'h0);

    // R5 PLL ready ignores writes
    pll_lock_i = 1'b1;
    wr(4'h0, 4'h8, 32'h0100_0000);
    @(negedge clk);
    rd(4'h0, r); check("R4 PLL ready", {31'b0, r[25]}, 32'h1);
    wr(4'h0, 4'h8, 32'h0100_0000);
    rd(4'h0, r); check("R5 PLL ready survives write of 0", {31'b0, r[25]}, 32'h1);

    // R7 interlock
    sysclk_sel_i = 2'd2;
    wr(4'h0, 4'h8, 32'h0);
    check("R7 clear blocked while selected", {31'b0, pll_en_o}, 32'h1);
    sysclk_sel_i = 2'd0; sysclk_src_i = 2'd2;
    wr(4'h0, 4'h8, 32'h0);
    check("R7 clear blocked while active", {31'b0, pll_en_o}, 32'h1);

    // R6 low-power wins over a write and the interlock
    wr(4'h0, 4'h4, 32'h0001_0000);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = '0; be_i = 4'hC; wdata_i = 32'h0101_0000;
    lp_entry_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0; be_i = '0; lp_entry_i = 1'b0;
    check("R6 PLL enable cleared", {31'b0, pll_en_o}, 32'h0);
    check("R6 crystal enable cleared", {31'b0, xosc_en_o}, 32'h0);
    check("R6 RC enable kept", {31'b0, irc_en_o}, 32'h1);

    // R8 crystal interlock, then RC released
    sysclk_src_i = 2'd1;
    wr(4'h0, 4'h4, 32'h0001_0000);
    wr(4'h0, 4'h4, 32'h0);
    check("R8 crystal clear blocked", {31'b0, xosc_en_o}, 32'h1);
    wr(4'h0, 4'h1, 32'h0000_0080);
    rd(4'h0, r); check("R8 RC clear allowed, ready drops", r[7:0], 32'h80);
    check("R3 trim output", {27'b0, trim_o}, 32'd16);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule